// File: doc/BRIEF.md
# Selectable-Order Burst Address Counter

This block produces the full word address for a four-beat memory burst. A burst starts when the load input is pulsed. The block then captures the external address. From that point it steps through the burst one beat per clock while the active-low advance input is held low. It keeps the current beat while advance is high. The upper address bits are captured at the load and stay fixed for the whole burst. Only the low bits move.

The low bits follow one of two orders, chosen by a level input that is not clocked. Linear order adds the beat number to the starting offset and wraps within the block of four. Interleaved order XORs the beat number with the starting offset. The block stores the starting offset and the beat number rather than the output address. Because of this, a change of order takes effect at once, at the current beat, and needs no reload. Strobe decoding, chip selects and the memory array are outside this block.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is asserted (rstN low), and after it is released with no load yet, addrOut is all zeros.
- R2: One clock edge after loadReq is high, addrOut equals the extAddr sampled at that edge, in either order mode.
- R3: With orderLinear = 1, beat n of a burst has low bits equal to (start + n) modulo 4, for example 01, 10, 11, 00 and 11, 00, 01, 10.
- R4: With orderLinear = 0, beat n of a burst has low bits equal to start XOR n, for example 01, 00, 11, 10 and 10, 11, 00, 01.
- R5: The beat advances at an edge only when advN is 0 and loadReq is 0. When advN is 1, addrOut keeps its value across edges.
- R6: loadReq takes priority over advance. A load during a burst, with advN low, restarts at the new address with beat 0.
- R7: An advance after the fourth beat wraps back to the starting address.
- R8: The bits of addrOut above the two low bits change only at a load. extAddr changes between loads have no effect on addrOut.
- R9: orderLinear acts without a clock. Changing it remaps the current beat on addrOut in the same cycle and keeps the beat number. For example, with start 01 at beat 1, addrOut low bits read 10 in linear order and 00 in interleaved order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| loadReq | input | 1 | Start a burst from extAddr at this edge |
| advN | input | 1 | Active-low advance to the next beat |
| orderLinear | input | 1 | 1 = linear order, 0 = interleaved order (level input, not clocked) |
| extAddr | input | ADDR_W (17) | Starting address of a burst |
| addrOut | output | ADDR_W (17) | Current burst address |

## Verification
The bench builds the block with the default parameters: a 17-bit address and a 2-bit beat counter. With these values every starting offset, both orders, and the wrap after the fourth beat are reached within a few cycles. A 15-bit upper field lets the bench drive distinct patterns into extAddr between loads and confirm that they never reach the output. The bench flips the order input in the middle of a burst, with no clock edge, to show that the output is remapped at once while the beat number is kept.

// File: rtl/burst_pkg.sv
`timescale 1ns/1ps
package burst_pkg;
  // Strobes passed from the control module to the datapath.
  typedef struct packed {
    logic loadEn;   // capture the external address, beat back to 0
    logic stepEn;   // move to the next beat
  } burstStrobe_t;
endpackage

// File: rtl/burst_ctrl.sv
`timescale 1ns/1ps
module burst_ctrl
  import burst_pkg::*;
(
  input  logic         loadReq,
  input  logic         advN,
  output burstStrobe_t strobes
);
  // A load wins over an advance. The advance input is active low.
  always_comb begin
    strobes.loadEn = loadReq;
    strobes.stepEn = !loadReq && !advN;
  end
endmodule

// File: rtl/burst_dp.sv
`timescale 1ns/1ps
module burst_dp
  import burst_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  burstStrobe_t      strobes,
  input  logic [ADDR_W-1:0] extAddr,
  input  logic              orderLinear,
  output logic [ADDR_W-1:0] addrOut
);
  localparam int UPPER_W = ADDR_W - BEAT_W;

  logic [UPPER_W-1:0] upperQ;
  logic [BEAT_W-1:0]  startQ;
  logic [BEAT_W-1:0]  beatQ;
  logic [BEAT_W-1:0]  lowLinear;
  logic [BEAT_W-1:0]  lowInterleave;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upperQ <= '0;
      startQ <= '0;
      beatQ  <= '0;
    end else if (strobes.loadEn) begin
      upperQ <= extAddr[ADDR_W-1:BEAT_W];
      startQ <= extAddr[BEAT_W-1:0];
      beatQ  <= '0;
    end else if (strobes.stepEn) begin
      beatQ  <= beatQ + BEAT_W'(1);   // wraps naturally after the last beat
    end
  end

  // Both orders are formed from the stored offset and beat number, one bit per lane for XOR.
  assign lowLinear = startQ + beatQ;
  for (genvar b = 0; b < BEAT_W; b++) begin : g_xorLane
    assign lowInterleave[b] = startQ[b] ^ beatQ[b];
  end

  always_comb begin
    addrOut[ADDR_W-1:BEAT_W] = upperQ;
    addrOut[BEAT_W-1:0]      = orderLinear ? lowLinear : lowInterleave;
  end
endmodule

// File: rtl/burst_addr_gen.sv
`timescale 1ns/1ps
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadReq,
  input  logic              advN,
  input  logic              orderLinear,
  input  logic [ADDR_W-1:0] extAddr,
  output logic [ADDR_W-1:0] addrOut
);
  burstStrobe_t strobes;

  burst_ctrl i_ctrl (
    .loadReq (loadReq),
    .advN    (advN),
    .strobes (strobes)
  );

  burst_dp #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .extAddr     (extAddr),
    .orderLinear (orderLinear),
    .addrOut     (addrOut)
  );
endmodule

// File: rtl/burst_addr_gen_chk.sv
`timescale 1ns/1ps
module burst_addr_gen_chk #(
  parameter int ADDR_W = 17,
  parameter int BEAT_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              loadReq,
  input logic              advN,
  input logic              orderLinear,
  input logic [ADDR_W-1:0] extAddr,
  input logic [ADDR_W-1:0] addrOut
);
  // R2: a load presents the captured address on the next cycle.
  a_r2_load_captures: assert property (@(posedge clk) disable iff (!rstN)
    loadReq |=> addrOut == $past(extAddr));

  // R5: with advance high and no load, the output holds (unless the order input moved).
  a_r5_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!loadReq && advN) |=>
      (addrOut == $past(addrOut)) || (orderLinear != $past(orderLinear)));

  // R8: the upper bits move only at a load.
  a_r8_upper_stable: assert property (@(posedge clk) disable iff (!rstN)
    !loadReq |=> addrOut[ADDR_W-1:BEAT_W] == $past(addrOut[ADDR_W-1:BEAT_W]));

  // R3: in linear order an advance adds one to the low bits, modulo the burst length.
  a_r3_linear_step: assert property (@(posedge clk) disable iff (!rstN)
    (!loadReq && !advN && orderLinear) |=>
      (!orderLinear ||
       addrOut[BEAT_W-1:0] == BEAT_W'($past(addrOut[BEAT_W-1:0]) + BEAT_W'(1))));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) i_chk (
  .clk         (clk),
  .rstN        (rstN),
  .loadReq     (loadReq),
  .advN        (advN),
  .orderLinear (orderLinear),
  .extAddr     (extAddr),
  .addrOut     (addrOut)
);

// File: tb/test_burst_addr_gen.sv
`timescale 1ns/1ps
module test_burst_addr_gen;
  localparam int ADDR_W = 17;

  logic              clk = 1'b0;
  logic              rstN;
  logic              loadReq;
  logic              advN;
  logic              orderLinear;
  logic [ADDR_W-1:0] extAddr;
  logic [ADDR_W-1:0] addrOut;

  int testCount = 0;
  int failCount = 0;

  always #2 clk = ~clk;   // 250 MHz

  burst_addr_gen i_burst_addr_gen (
    .clk         (clk),
    .rstN        (rstN),
    .loadReq     (loadReq),
    .advN        (advN),
    .orderLinear (orderLinear),
    .extAddr     (extAddr),
    .addrOut     (addrOut)
  );

  // Expected address from the requirement definitions.
  function automatic logic [ADDR_W-1:0] expAddr(input logic [ADDR_W-1:0] start,
                                                input int n, input logic lin);
    logic [1:0] beat;
    logic [1:0] low;
    beat = 2'(n);
    low  = lin ? 2'(start[1:0] + beat) : (start[1:0] ^ beat);
    return {start[ADDR_W-1:2], low};
  endfunction

  task automatic check(input string req, input logic [ADDR_W-1:0] act,
                       input logic [ADDR_W-1:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic doLoad(input logic [ADDR_W-1:0] a, input logic lin);
    loadReq = 1'b1; advN = 1'b1; extAddr = a; orderLinear = lin;
    tick();
    loadReq = 1'b0;
  endtask

  // Load, then advance through five beats (includes the wrap) and check each one.
  task automatic runBurst(input string req, input logic [ADDR_W-1:0] a, input logic lin);
    doLoad(a, lin);
    check("R2", addrOut, a);
    for (int n = 1; n <= 4; n++) begin
      advN = 1'b0;
      tick();
      check(req, addrOut, expAddr(a, n, lin));
    end
    check("R7", addrOut, a);
    advN = 1'b1;
  endtask

  task automatic testReset();
    rstN = 1'b0; loadReq = 1'b0; advN = 1'b1; orderLinear = 1'b1; extAddr = '0;
    #1;
    check("R1", addrOut, '0);
    tick(); tick();
    rstN = 1'b1;
    tick();
    check("R1", addrOut, '0);
  endtask

  task automatic testHold();
    logic [ADDR_W-1:0] a;
    a = 17'h0B3C6;
    doLoad(a, 1'b1);
    advN = 1'b0; tick();
    check("R5", addrOut, expAddr(a, 1, 1'b1));
    advN = 1'b1;
    for (int i = 0; i < 3; i++) begin
      tick();
      check("R5", addrOut, expAddr(a, 1, 1'b1));
    end
  endtask

  task automatic testPriority();
    logic [ADDR_W-1:0] a;
    logic [ADDR_W-1:0] b;
    a = 17'h12340; b = 17'h05557;
    doLoad(a, 1'b0);
    advN = 1'b0; tick(); tick();
    loadReq = 1'b1; extAddr = b; advN = 1'b0;
    tick();
    loadReq = 1'b0;
    check("R6", addrOut, b);
    tick();
    check("R6", addrOut, expAddr(b, 1, 1'b0));
    advN = 1'b1;
  endtask

  task automatic testUpper();
    logic [ADDR_W-1:0] a;
    a = 17'h1F00E;
    doLoad(a, 1'b1);
    for (int n = 1; n <= 3; n++) begin
      extAddr = 17'(n * 17'h0AAA5);
      advN = 1'b0;
      tick();
      check("R8", addrOut, expAddr(a, n, 1'b1));
    end
    advN = 1'b1; extAddr = 17'h00FFF;
    tick();
    check("R8", addrOut, expAddr(a, 3, 1'b1));
  endtask

  task automatic testModeFlip();
    logic [ADDR_W-1:0] a;
    a = 17'h06661;
    doLoad(a, 1'b1);
    advN = 1'b0; tick(); advN = 1'b1;
    check("R9", addrOut, {a[ADDR_W-1:2], 2'b10});
    orderLinear = 1'b0; #1;
    check("R9", addrOut, {a[ADDR_W-1:2], 2'b00});
    orderLinear = 1'b1; #1;
    check("R9", addrOut, {a[ADDR_W-1:2], 2'b10});
  endtask

  initial begin
    #20000;
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    testReset();
    runBurst("R3", 17'h0A5C1, 1'b1);   // linear from 01
    runBurst("R3", 17'h1234F, 1'b1);   // linear from 11
    runBurst("R4", 17'h0A5C1, 1'b0);   // interleaved from 01
    runBurst("R4", 17'h00F02, 1'b0);   // interleaved from 10
    testHold();
    testPriority();
    testUpper();
    testModeFlip();
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule